// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns pairs of stereo samples into a three-wire serial audio stream made of a bit clock, a frame clock and one data line. It derives the bit clock from the system clock by a fixed divider. Each frame lasts 64 bit-clock periods, split into two 32-slot halves, one half per channel. The frame clock toggles once per half. The data line carries the sample most significant bit first, in two's complement form. Two control fields pick the word width and the justification format. The formats are I2S, left-justified and right-justified. The widths are 16, 20 and 24 bits.

A producer hands over one left/right pair at a time through a valid/ready handshake into a single holding register. At every frame boundary the block moves the held pair and the current control settings into its frame registers. Each frame is therefore serialized with one sample pair and one setting throughout. If no pair is waiting at the boundary, the frame carries silence.

Top module: `audio_serial_tx`

## Requirements
- R1: The bit clock has a period of 2*HALF_DIV system clocks and starts low out of reset. One frame spans 64 bit-clock periods. The frame clock holds one level for 32 bit periods and can change only in the first slot of a half.
- R2: The data and frame-clock outputs change only in the system-clock cycle in which the bit clock falls, so they are stable at every rising bit-clock edge.
- R3: Format code 00 is I2S, and so is the spare code 11. The frame clock is low for the left half and high for the right half. The MSB is in slot 1 of each half, and slots after the LSB are 0.
- R4: Format code 01 is left-justified. The frame clock is high for the left half. The MSB is in slot 0 of each half, and slots after the LSB are 0.
- R5: Format code 10 is right-justified. The frame clock is high for the left half. The LSB is in slot 31 of each half, and the slots before the MSB are 0.
- R6: Width code 00 selects 16 bits, 01 selects 20 bits, and 10 and 11 select 24 bits. Samples enter right-aligned in the 24-bit inputs. Input bits above the selected width have no effect on the line.
- R7: Samples go out MSB first and unaltered. Full-scale positive (0 then all ones) and full-scale negative (1, zeros, final 1) appear bit for bit.
- R8: in_ready is high while the holding register is empty. An accepted pair drops in_ready on the next cycle. The holding register moves into the frame registers at the next frame start, which frees it again.
- R9: Format and width inputs are sampled only at a frame start. Changes made within a frame do not affect that frame.
- R10: A frame that starts with no sample pair waiting sends 0 in all of its data slots.
- R11: During reset the bit clock, frame clock and data line are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_fmt | input | 2 | Justification format code |
| cfg_wsel | input | 2 | Word width code |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register free |
| in_left | input | DATA_W | Left sample, right-aligned two's complement |
| in_right | input | DATA_W | Right sample, right-aligned two's complement |
| bclk | output | 1 | Generated bit clock |
| lrclk | output | 1 | Generated frame clock |
| sdata | output | 1 | Serial data, changes on bit-clock fall |

## Verification
The assertions assume a producer that holds in_valid and the sample words steady until the handshake completes. They also assume the control inputs are synchronous to clk, so a frame-start sample of them is meaningful. The bench drives every input only at the falling edge of clk. It offers each pair as soon as in_ready is seen and clears in_valid right after the accepting edge. It toggles the control fields mid-frame only to values that are restored before the next frame boundary, so each frame's expected setting is known.

// File: rtl/atx_pkg.sv
package atx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'b00,
    FMT_LEFT  = 2'b01,
    FMT_RIGHT = 2'b10,
    FMT_SPARE = 2'b11
  } fmt_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] wsel;
  } frame_cfg_t;

  // Word width in bits for a width code.
  function automatic logic [4:0] width_of(input logic [1:0] wsel);
    case (wsel)
      2'b00:   width_of = 5'd16;
      2'b01:   width_of = 5'd20;
      default: width_of = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/atx_clkgen.sv
module atx_clkgen #(
  parameter int HALF_DIV    = 2,
  parameter int FRAME_SLOTS = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic                           bclk,
  output logic                           fall_stb,
  output logic                           frame_start,
  output logic [$clog2(FRAME_SLOTS)-1:0] slot_nxt
);
  localparam int CNT_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SLOT_W = $clog2(FRAME_SLOTS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bclk_q, bclk_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              term;

  always_comb begin
    term     = (cnt_q == CNT_W'(HALF_DIV - 1));
    fall_stb = term && bclk_q;
    slot_nxt = slot_q + SLOT_W'(1);
    cnt_d    = term ? '0 : cnt_q + CNT_W'(1);
    bclk_d   = term ? ~bclk_q : bclk_q;
    slot_d   = fall_stb ? slot_nxt : slot_q;
    frame_start = fall_stb && (slot_q == {SLOT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
      slot_q <= {SLOT_W{1'b1}};
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
      slot_q <= slot_d;
    end
  end

  assign bclk = bclk_q;

  // R1
  slot_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk_q) |-> (slot_q != $past(slot_q)));

endmodule

// File: rtl/atx_sample_buf.sv
module atx_sample_buf
  import atx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  frame_cfg_t        cfg_in,
  output logic [DATA_W-1:0] view_left,
  output logic [DATA_W-1:0] view_right,
  output frame_cfg_t        view_cfg
);
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic [DATA_W-1:0] cur_l_q, cur_l_d, cur_r_q, cur_r_d;
  frame_cfg_t        cfg_q, cfg_d;
  logic              accept;

  always_comb begin
    accept   = in_valid && !pend_q;
    pend_d   = pend_q;
    hold_l_d = hold_l_q;
    hold_r_d = hold_r_q;
    cur_l_d  = cur_l_q;
    cur_r_d  = cur_r_q;
    cfg_d    = cfg_q;
    if (frame_start) begin
      cur_l_d = pend_q ? hold_l_q : '0;
      cur_r_d = pend_q ? hold_r_q : '0;
      cfg_d   = cfg_in;
      pend_d  = 1'b0;
    end
    if (accept) begin
      hold_l_d = in_left;
      hold_r_d = in_right;
      pend_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      hold_l_q <= '0;
      hold_r_q <= '0;
      cur_l_q  <= '0;
      cur_r_q  <= '0;
      cfg_q    <= '0;
    end else begin
      pend_q   <= pend_d;
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      cur_l_q  <= cur_l_d;
      cur_r_q  <= cur_r_d;
      cfg_q    <= cfg_d;
    end
  end

  // The slot being entered at a frame start must see the freshly loaded frame.
  assign view_left  = frame_start ? cur_l_d : cur_l_q;
  assign view_right = frame_start ? cur_r_d : cur_r_q;
  assign view_cfg   = frame_start ? cfg_d   : cfg_q;
  assign in_ready   = !pend_q;

  // R8
  full_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_q));
  // R10
  silence_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pend_q) |=> (cur_l_q == '0 && cur_r_q == '0));

endmodule

// File: rtl/atx_slot_map.sv
module atx_slot_map
  import atx_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int SLOTS_PER_CH = 32
) (
  input  logic [$clog2(2*SLOTS_PER_CH)-1:0] slot,
  input  frame_cfg_t                        cfg,
  input  logic [DATA_W-1:0]                 left,
  input  logic [DATA_W-1:0]                 right,
  output logic                              bit_out,
  output logic                              lr_out
);
  localparam int PW = $clog2(SLOTS_PER_CH);

  logic              half;
  logic [PW-1:0]     pos;
  logic [4:0]        w;
  logic [4:0]        idx;
  logic [DATA_W-1:0] smp;

  always_comb begin
    half    = slot[PW];
    pos     = slot[PW-1:0];
    w       = width_of(cfg.wsel);
    smp     = half ? right : left;
    bit_out = 1'b0;
    idx     = '0;
    case (fmt_e'(cfg.fmt))
      FMT_LEFT: begin
        lr_out = ~half;
        if (pos < w) begin
          idx     = w - 5'd1 - pos;
          bit_out = smp[idx];
        end
      end
      FMT_RIGHT: begin
        lr_out = ~half;
        if (pos >= 5'(SLOTS_PER_CH) - w) begin
          idx     = 5'(SLOTS_PER_CH - 1) - pos;
          bit_out = smp[idx];
        end
      end
      default: begin
        lr_out = half;
        if (pos != '0 && pos <= w) begin
          idx     = w - pos;
          bit_out = smp[idx];
        end
      end
    endcase
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import atx_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int HALF_DIV     = 2,
  parameter int SLOTS_PER_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_wsel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdata
);
  localparam int FRAME_SLOTS = 2 * SLOTS_PER_CH;
  localparam int SLOT_W      = $clog2(FRAME_SLOTS);
  localparam int PW          = $clog2(SLOTS_PER_CH);

  logic              fall_stb, frame_start;
  logic [SLOT_W-1:0] slot_nxt;
  logic [DATA_W-1:0] view_left, view_right;
  frame_cfg_t        view_cfg, cfg_in;
  logic              map_bit, map_lr;
  logic              sdata_q, sdata_d, lrclk_q, lrclk_d;

  assign cfg_in = '{fmt: cfg_fmt, wsel: cfg_wsel};

  atx_clkgen #(.HALF_DIV(HALF_DIV), .FRAME_SLOTS(FRAME_SLOTS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fall_stb(fall_stb),
    .frame_start(frame_start), .slot_nxt(slot_nxt)
  );

  atx_sample_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .cfg_in(cfg_in),
    .view_left(view_left), .view_right(view_right), .view_cfg(view_cfg)
  );

  atx_slot_map #(.DATA_W(DATA_W), .SLOTS_PER_CH(SLOTS_PER_CH)) u_map (
    .slot(slot_nxt), .cfg(view_cfg), .left(view_left), .right(view_right),
    .bit_out(map_bit), .lr_out(map_lr)
  );

  always_comb begin
    sdata_d = fall_stb ? map_bit : sdata_q;
    lrclk_d = fall_stb ? map_lr  : lrclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= 1'b0;
      lrclk_q <= 1'b0;
    end else begin
      sdata_q <= sdata_d;
      lrclk_q <= lrclk_d;
    end
  end

  assign sdata = sdata_q;
  assign lrclk = lrclk_q;

  // R2
  sdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(sdata_q));
  // R2
  lrclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_stb |=> $stable(lrclk_q));
  // R1
  lr_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && slot_nxt[PW-1:0] != '0) |=> $stable(lrclk_q));

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;
  localparam int HALF_DIV = 2;
  localparam int NF = 48;       // frames carrying data
  localparam int NT = NF + 2;   // plus underrun frames

  logic        clk, rst_n;
  logic [1:0]  cfg_fmt, cfg_wsel;
  logic        in_valid, in_ready;
  logic [23:0] in_left, in_right;
  logic        bclk, lrclk, sdata;

  int tests, fails;
  bit done;

  logic [1:0]  plan_fmt [0:NT+1];
  logic [1:0]  plan_ws  [0:NT+1];
  logic [23:0] smp_l [0:NT-1];
  logic [23:0] smp_r [0:NT-1];

  audio_serial_tx #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wsel(cfg_wsel),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic int width_bits(input logic [1:0] ws);
    return (ws == 2'b00) ? 16 : (ws == 2'b01) ? 20 : 24;
  endfunction

  // Expected 32-slot half, slot 0 at bit 31.
  function automatic logic [31:0] half_word(input logic [1:0] fmt, input logic [1:0] ws,
                                             input logic [23:0] s);
    int w;
    logic [31:0] v;
    w = width_bits(ws);
    v = {8'd0, s} & ((32'd1 << w) - 32'd1);
    case (fmt)
      2'b01:   return v << (32 - w);
      2'b10:   return v;
      default: return v << (31 - w);
    endcase
  endfunction

  function automatic logic [23:0] gen(input int f, input int ch);
    int w;
    logic [23:0] mask, v;
    w = width_bits(plan_ws[f]);
    mask = 24'((32'd1 << w) - 32'd1);
    case (f / 16)
      0: v = (ch == 0) ? 24'((32'd1 << (w - 1)) - 1) : 24'((32'd1 << (w - 1)) | 1);
      1: v = 24'(f * 1103515245 + 12345 + ch * 7919);
      default: v = {f[7:0], ~f[7:0], 8'hA5} ^ {23'd0, ch[0]};
    endcase
    // R6: junk above the width must be ignored
    return (v & mask) | (24'h5A5A5A & ~mask);
  endfunction

  function automatic string fmt_tag(input int f);
    if (f >= NF) return "R10";
    case (plan_fmt[f])
      2'b01:   return "R4 R6 R7 R9";
      2'b10:   return "R5 R6 R7 R9";
      default: return "R3 R6 R7 R9";
    endcase
  endfunction

  // Producer: offers each pair as soon as the holding register is free.
  task automatic send(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 ready drops after accept", {63'd0, in_ready}, 64'd0);
  endtask

  // Monitor state
  logic [63:0] bits_cap, lr_cap;
  int slot, frame, since_rise, bad_period, bad_change;
  bit first_seen;
  logic bclk_p, sd_p, lr_p;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      since_rise++;
      if ((sdata !== sd_p || lrclk !== lr_p) && !(bclk_p && !bclk)) bad_change++;
      if (bclk && !bclk_p) begin
        if (!first_seen) begin
          first_seen = 1'b1;
        end else begin
          if (since_rise != 2 * HALF_DIV) bad_period++;
          bits_cap[63 - slot] = sdata;
          lr_cap[63 - slot]   = lrclk;
          slot++;
          if (slot == 20) begin
            cfg_fmt = ~plan_fmt[frame + 1]; cfg_wsel = ~plan_ws[frame + 1];
          end
          if (slot == 50) begin
            cfg_fmt = plan_fmt[frame + 1]; cfg_wsel = plan_ws[frame + 1];
          end
          if (slot == 64) begin
            logic [63:0] lr_exp;
            logic [1:0] fm;
            logic [23:0] el, er;
            fm = plan_fmt[frame];
            el = (frame < NF) ? smp_l[frame] : 24'd0;
            er = (frame < NF) ? smp_r[frame] : 24'd0;
            if (fm == 2'b01 || fm == 2'b10) lr_exp = {{32{1'b1}}, 32'd0};
            else lr_exp = {32'd0, {32{1'b1}}};
            check({fmt_tag(frame), " left"},  {32'd0, bits_cap[63:32]},
                  {32'd0, half_word(fm, plan_ws[frame], el)});
            check({fmt_tag(frame), " right"}, {32'd0, bits_cap[31:0]},
                  {32'd0, half_word(fm, plan_ws[frame], er)});
            check({fmt_tag(frame), " R1 frame clock"}, lr_cap, lr_exp);
            check("R1 bit clock period", 64'(bad_period), 64'd0);
            slot = 0;
            frame++;
            if (frame == NT) begin
              check("R2 outputs change only at bit clock fall", 64'(bad_change), 64'd0);
              finish_run();
            end
          end
        end
        since_rise = 0;
      end
    end
    bclk_p = bclk; sd_p = sdata; lr_p = lrclk;
  end

  initial begin
    tests = 0; fails = 0; done = 1'b0;
    slot = 0; frame = 0; since_rise = 0; bad_period = 0; bad_change = 0;
    first_seen = 1'b0; bclk_p = 1'b0; sd_p = 1'b0; lr_p = 1'b0;
    for (int f = 0; f < NT + 2; f++) begin
      plan_fmt[f] = 2'(f % 4);
      plan_ws[f]  = (f < NF) ? 2'((f / 4) % 4) : 2'b10;
    end
    for (int f = 0; f < NT; f++) begin
      smp_l[f] = gen(f, 0);
      smp_r[f] = gen(f, 1);
    end
    cfg_fmt = plan_fmt[0]; cfg_wsel = plan_ws[0];
    in_valid = 1'b0; in_left = '0; in_right = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11
    check("R11 reset outputs", {60'd0, bclk, lrclk, sdata, in_ready}, 64'h1);
    rst_n = 1'b1;
    for (int f = 0; f < NF; f++) send(smp_l[f], smp_r[f]);
  end

  initial begin
    #(5ns * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule